// File: doc/BRIEF.md
# Variable-Length Buffered SPI Master

This block is one SPI master channel with a simple synchronous register bus. Software picks a frame length of 1 to 16 bits, then writes a word into a transmit holding register. The block moves that word into its shift register, lowers chip-select, and clocks the frame out most-significant bit first on MOSI. It samples MISO on the same serial clock. At the end of the frame the received bits go into a receive holding register. Two flags, exposed as ports, tell software when the transmit holding register may be written (`tx_empty`) and when a received word is waiting (`rx_full`).

The serial clock runs at half the system clock in SPI mode 0 and idles low. A word written while the previous frame is still shifting out is sent straight after it, so a stream of words forms one burst with chip-select held low. A control register holds a module enable and a self-clearing soft reset. Dropping the enable freezes the serial clock. The soft reset returns the shifting logic to idle and leaves the holding registers alone.

Register map (2-bit word address): 0 = control (bit 0 enable, bit 1 soft reset), 1 = format (bits 3:0, frame length minus one), 2 = transmit word (write fills the buffer, read returns it), 3 = received word (read clears `rx_full`).

Top module: `spi_var_master`

## Requirements
- R1: After reset: `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `tx_empty` is 1 and `rx_full` is 0. The control register reads 0x0000 and the format register reads 0x000F.
- R2: In the control register at address 0, bit 0 is the enable and bit 1 is the soft reset. Bits 15:2 always read as 0, whatever was written to them.
- R3: Writing 1 to control bit 1 makes that bit read 1 in the next cycle and 0 in the cycle after. The soft reset ends any frame in progress: `spi_cs_n` goes high, no received word is delivered, and the transmit word and its flag are kept. Writing 0 to bit 1 leaves a running frame undisturbed.
- R4: While the enable is 0, `spi_sclk` holds its level and no new frame starts. A word left in the transmit buffer keeps `tx_empty` at 0 and is sent once the enable is set.
- R5: A write to address 2 sets `tx_empty` to 0. With the enable at 1 and the shifter idle, the word moves into the shifter on the next clock edge: `tx_empty` returns to 1 and `spi_cs_n` falls.
- R6: With L = format value + 1, exactly the low L bits of the transmit word go out on `spi_mosi`, starting with bit L-1 and ending with bit 0. The bits above L-1 are never sent.
- R7: The received word holds the L bits sampled in the frame. The first sampled bit lands in bit L-1. Bits above L-1 read as 0.
- R8: The bus uses SPI mode 0. While a frame runs, `spi_sclk` has a period of two system clocks. `spi_mosi` changes only on a falling `spi_sclk`, `spi_miso` is sampled on a rising one, and `spi_sclk` is low whenever `spi_cs_n` is high.
- R9: If the transmit buffer is full when a frame ends, the next frame starts without a gap in chip-select. `spi_cs_n` stays low for the whole burst.
- R10: The end of a frame sets `rx_full`, and a read of address 3 clears it. If that read falls in the same cycle as a frame end, the read returns the older word, `rx_full` stays 1 and the new word is kept.
- R11: Format value 0 gives 1-bit frames and format value 15 gives 16-bit frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading address 3 clears `rx_full`) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tx_empty | output | 1 | Transmit holding register may be written |
| rx_full | output | 1 | Received word waiting in holding register |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip-select, active low |

## Verification
Two events can fall in the same cycle: the end of a frame, which loads the receive holding register, and a software read of that register. The bench runs a two-frame burst without reading the first word. It watches the serial lines until the last rising clock of the second frame, then drives the read in the very next cycle, so that the read edge is the frame-end edge. The check passes only if that read returns the first word, `rx_full` is still 1 afterwards, and a second read returns the second word.

// File: rtl/spi_vm_pkg.sv
package spi_vm_pkg;
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_FMT  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_TXD  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_RXD  = 2'd3;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 1;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_e;
endpackage

// File: rtl/spi_vm_regfile.sv
module spi_vm_regfile
  import spi_vm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  tx_take,
  input  logic                  rx_done,
  input  logic [DATA_W-1:0]     rx_word,
  output logic                  mod_en,
  output logic                  srst_q,
  output logic [LEN_W-1:0]      len_code,
  output logic                  tx_full,
  output logic [DATA_W-1:0]     tx_word,
  output logic                  rx_full,
  output logic                  tx_wr_evt
);
  logic              ctrl_wr;
  logic              fmt_wr;
  logic              rx_rd_evt;
  logic [DATA_W-1:0] rx_buf;

  assign ctrl_wr   = bus_wr && (bus_addr == ADR_CTRL);
  assign fmt_wr    = bus_wr && (bus_addr == ADR_FMT);
  assign tx_wr_evt = bus_wr && (bus_addr == ADR_TXD);
  assign rx_rd_evt = bus_rd && (bus_addr == ADR_RXD);

  // control register: enable is held, soft reset lives for one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= ctrl_wr && bus_wdata[CTRL_SRST_BIT];
      if (ctrl_wr) mod_en <= bus_wdata[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_code <= '1;
    else if (fmt_wr) len_code <= bus_wdata[LEN_W-1:0];
  end

  // transmit holding register; a write outranks a same-cycle take
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_full <= 1'b0;
    end else if (tx_wr_evt) begin
      tx_word <= bus_wdata;
      tx_full <= 1'b1;
    end else if (tx_take) begin
      tx_full <= 1'b0;
    end
  end

  // receive holding register; frame end outranks a same-cycle read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
    end else if (rx_done) begin
      rx_buf  <= rx_word;
      rx_full <= 1'b1;
    end else if (rx_rd_evt) begin
      rx_full <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_CTRL: begin
        bus_rdata[CTRL_EN_BIT]   = mod_en;
        bus_rdata[CTRL_SRST_BIT] = srst_q;
      end
      ADR_FMT:  bus_rdata[LEN_W-1:0] = len_code;
      ADR_TXD:  bus_rdata = tx_word;
      ADR_RXD:  bus_rdata = rx_buf;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_vm_clkgen.sv
module spi_vm_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mod_en,
  input  logic srst,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  logic ph_q;
  logic tick;

  assign tick     = run && mod_en && !srst;
  assign rise_evt = tick && !ph_q;
  assign fall_evt = tick && ph_q;
  assign sclk     = run && ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph_q <= 1'b0;
    else if (!run || srst)   ph_q <= 1'b0;
    else if (tick)           ph_q <= ~ph_q;
  end
endmodule

// File: rtl/spi_vm_shifter.sv
module spi_vm_shifter
  import spi_vm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              srst,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              miso,
  output logic              run,
  output logic              tx_take,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              mosi,
  output logic              cs_n
);
  sh_state_e         state_q;
  logic [DATA_W-1:0] txsh_q;
  logic [DATA_W-1:0] rxsh_q;
  logic [LEN_W-1:0]  bitcnt_q;
  logic [LEN_W-1:0]  lenq_q;
  logic              start_idle;
  logic              chain_next;

  // place bit (code) of the word at the MSB of the shifter
  function automatic logic [DATA_W-1:0] align_msb(input logic [DATA_W-1:0] w,
                                                  input logic [LEN_W-1:0]  code);
    int sh;
    sh = DATA_W - 1 - int'(code);
    return w << sh;
  endfunction

  // ones in bits 0..code
  function automatic logic [DATA_W-1:0] low_mask(input logic [LEN_W-1:0] code);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i <= int'(code));
    return m;
  endfunction

  assign run        = (state_q == SH_RUN);
  assign cs_n       = !run;
  assign mosi       = run && txsh_q[DATA_W-1];
  assign start_idle = !run && mod_en && tx_full && !srst;
  assign rx_done    = run && fall_evt && (bitcnt_q == '0) && !srst;
  assign chain_next = rx_done && mod_en && tx_full;
  assign tx_take    = start_idle || chain_next;
  assign rx_word    = rxsh_q & low_mask(lenq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SH_IDLE;
      txsh_q   <= '0;
      rxsh_q   <= '0;
      bitcnt_q <= '0;
      lenq_q   <= '0;
    end else if (srst) begin
      state_q  <= SH_IDLE;
      txsh_q   <= '0;
      rxsh_q   <= '0;
      bitcnt_q <= '0;
    end else if (tx_take) begin
      state_q  <= SH_RUN;
      txsh_q   <= align_msb(tx_word, len_code);
      bitcnt_q <= len_code;
      lenq_q   <= len_code;
    end else if (rx_done) begin
      state_q <= SH_IDLE;
    end else if (run) begin
      if (rise_evt) rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
      if (fall_evt) begin
        txsh_q   <= {txsh_q[DATA_W-2:0], 1'b0};
        bitcnt_q <= bitcnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_var_master.sv
module spi_var_master
  import spi_vm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  tx_empty,
  output logic                  rx_full,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic                  spi_cs_n
);
  localparam int LEN_W = $clog2(DATA_W);

  // named internal events, observed by the bound checker
  logic              mod_en;
  logic              srst_q;
  logic [LEN_W-1:0]  len_code;
  logic              tx_full;
  logic [DATA_W-1:0] tx_word;
  logic              tx_take;
  logic              tx_wr_evt;
  logic              rx_done;
  logic [DATA_W-1:0] rx_word;
  logic              run;
  logic              rise_evt;
  logic              fall_evt;

  assign tx_empty = !tx_full;

  spi_vm_regfile #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_take(tx_take), .rx_done(rx_done), .rx_word(rx_word),
    .mod_en(mod_en), .srst_q(srst_q), .len_code(len_code),
    .tx_full(tx_full), .tx_word(tx_word), .rx_full(rx_full),
    .tx_wr_evt(tx_wr_evt)
  );

  spi_vm_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .mod_en(mod_en), .srst(srst_q),
    .sclk(spi_sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  spi_vm_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .srst(srst_q),
    .tx_full(tx_full), .tx_word(tx_word), .len_code(len_code),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .miso(spi_miso),
    .run(run), .tx_take(tx_take), .rx_done(rx_done), .rx_word(rx_word),
    .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/spi_vm_checker.sv
module spi_vm_checker (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic tx_empty,
  input logic rx_full,
  input logic mod_en,
  input logic srst_q,
  input logic tx_take,
  input logic tx_wr_evt,
  input logic rx_done
);
  assert_idle_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sclk && !spi_mosi));

  assert_mosi_held_at_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  assert_sclk_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !srst_q) |=> $stable(spi_sclk));

  assert_srst_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> spi_cs_n);

  assert_take_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !tx_wr_evt) |=> tx_empty);

  assert_done_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full);

  assert_cs_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> ($past(rx_done) || $past(srst_q)));
endmodule

bind spi_var_master spi_vm_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
  .tx_empty(tx_empty), .rx_full(rx_full),
  .mod_en(mod_en), .srst_q(srst_q),
  .tx_take(tx_take), .tx_wr_evt(tx_wr_evt), .rx_done(rx_done)
);

// File: tb/spi_var_master_bench.sv
module spi_var_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        tx_empty, rx_full, spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // slave model state
  int          mlen = 16;
  int          ridx = 0;
  int          fr = 0;
  int          cs_rises = 0;
  int          bad_period = 0;
  int          cyc = 0;
  int          last_rise = -1;
  logic        prev_sclk = 1'b0;
  logic        prev_cs = 1'b1;
  logic [15:0] cap_sh = 16'h0;
  logic [15:0] slv_words [4];
  logic [15:0] cap_words [4];

  spi_var_master u_spi_var_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] keep_low(input int n);
    logic [31:0] v;
    v = (32'h1 << n) - 32'h1;
    return v[15:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_rx();
    for (int k = 0; k < 200 && !rx_full; k++) @(negedge clk);
  endtask

  // slave model: records MOSI at each rising SCLK, serves MISO bits MSB first
  initial begin
    forever begin
      @(posedge clk); #2;
      cyc++;
      if (spi_cs_n) begin
        ridx = 0; last_rise = -1; cap_sh = 16'h0;
        if (!prev_cs) cs_rises++;
      end else if (spi_sclk && !prev_sclk) begin
        if (last_rise >= 0 && cyc - last_rise != 2) bad_period++;
        last_rise = cyc;
        cap_sh = {cap_sh[14:0], spi_mosi};
        ridx++;
        if (ridx == mlen) begin
          if (fr < 4) cap_words[fr] = cap_sh;
          fr++; ridx = 0; cap_sh = 16'h0;
        end
      end
      prev_sclk = spi_sclk;
      prev_cs = spi_cs_n;
      spi_miso = (fr < 4) ? slv_words[fr][mlen-1-ridx] : 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    report();
  end

  task automatic xfer(input int code, input logic [15:0] txw, input logic [15:0] slv,
                      input string tag);
    logic [15:0] r;
    logic [15:0] m;
    m = keep_low(code + 1);
    mlen = code + 1; fr = 0; slv_words[0] = slv; cap_words[0] = 16'h0;
    bus_write(2'd1, 16'(code));
    bus_write(2'd2, txw);
    @(negedge clk);
    chk({tag, " R5 tx_empty after start"}, 32'(tx_empty), 32'h1);
    chk({tag, " R5 cs_n low after start"}, 32'(spi_cs_n), 32'h0);
    wait_rx();
    bus_read(2'd3, r);
    chk({tag, " R7 received word"}, 32'(r), 32'(slv & m));
    chk({tag, " R6 sent word"}, 32'(cap_words[0]), 32'(txw & m));
    chk({tag, " R10 rx_full cleared by read"}, 32'(rx_full), 32'h0);
  endtask

  initial begin
    logic [15:0] r;
    int seed;
    seed = $urandom(32'h5EED17);
    for (int i = 0; i < 4; i++) begin slv_words[i] = 16'h0; cap_words[i] = 16'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", 32'(spi_cs_n), 32'h1);
    chk("R1 sclk", 32'(spi_sclk), 32'h0);
    chk("R1 mosi", 32'(spi_mosi), 32'h0);
    chk("R1 tx_empty", 32'(tx_empty), 32'h1);
    chk("R1 rx_full", 32'(rx_full), 32'h0);
    bus_read(2'd0, r); chk("R1 control", 32'(r), 32'h0);
    bus_read(2'd1, r); chk("R1 format", 32'(r), 32'h000F);

    // R2 reserved bits
    bus_write(2'd0, 16'hFFFD);
    bus_read(2'd0, r); chk("R2 reserved read zero", 32'(r), 32'h0001);

    // R11 extremes and a mid length, upper bits set to show they are ignored
    xfer(15, 16'hA53C, 16'h3CA5, "R11 len16");
    xfer(0, 16'hFFFF, 16'hFFFF, "R11 len1");
    xfer(7, 16'h12F0, 16'hBEEF, "R6 len8");

    // R3 writing 0 to soft reset leaves a running frame alone
    mlen = 16; fr = 0; slv_words[0] = 16'h6C39;
    bus_write(2'd1, 16'h000F);
    bus_write(2'd2, 16'h9E07);
    for (int k = 0; k < 100 && ridx < 5; k++) @(negedge clk);
    bus_write(2'd0, 16'h0001);
    wait_rx();
    bus_read(2'd3, r);
    chk("R3 write 0 no effect rx", 32'(r), 32'h6C39);
    chk("R3 write 0 no effect tx", 32'(cap_words[0]), 32'h9E07);

    // constrained random frames
    for (int n = 0; n < 24; n++) begin
      int code;
      logic [15:0] tw, sw;
      code = int'($urandom % 16);
      tw = 16'($urandom);
      sw = 16'($urandom);
      xfer(code, tw, sw, "R6 R7 random");
    end

    // R9 burst and R10 read colliding with frame end
    begin
      int rises0;
      mlen = 4; fr = 0;
      slv_words[0] = 16'h0009; slv_words[1] = 16'h0006;
      bus_write(2'd1, 16'h0003);
      rises0 = cs_rises;
      bus_write(2'd2, 16'hFF0A);
      @(negedge clk);
      bus_write(2'd2, 16'h0005);
      for (int k = 0; k < 100 && !(fr == 2 && spi_sclk); k++) @(negedge clk);
      bus_read(2'd3, r);
      chk("R10 collision read returns older word", 32'(r), 32'h0009);
      chk("R10 collision keeps rx_full", 32'(rx_full), 32'h1);
      bus_read(2'd3, r);
      chk("R10 collision new word kept", 32'(r), 32'h0006);
      chk("R9 first frame sent", 32'(cap_words[0]), 32'h000A);
      chk("R9 second frame sent", 32'(cap_words[1]), 32'h0005);
      for (int k = 0; k < 20 && !spi_cs_n; k++) @(negedge clk);
      @(negedge clk);
      chk("R9 single chip-select burst", 32'(cs_rises - rises0), 32'h1);
    end

    // R4 enable low freezes clock; R3 soft reset aborts
    begin
      logic s;
      int changes;
      mlen = 8; fr = 0; slv_words[0] = 16'h00AA;
      bus_write(2'd1, 16'h0007);
      bus_write(2'd2, 16'h005A);
      for (int k = 0; k < 100 && ridx < 3; k++) @(negedge clk);
      bus_write(2'd0, 16'h0000);
      s = spi_sclk; changes = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (spi_sclk !== s) changes++;
      end
      chk("R4 sclk frozen while disabled", 32'(changes), 32'h0);
      chk("R4 frame held while disabled", 32'(spi_cs_n), 32'h0);
      bus_write(2'd0, 16'h0002);
      bus_read(2'd0, r);
      chk("R3 soft reset reads 1", 32'(r), 32'h0002);
      chk("R3 cs_n high after soft reset", 32'(spi_cs_n), 32'h1);
      bus_read(2'd0, r);
      chk("R3 soft reset self-clears", 32'(r), 32'h0000);
      chk("R3 aborted frame not delivered", 32'(rx_full), 32'h0);

      fr = 0; slv_words[0] = 16'h0081;
      bus_write(2'd2, 16'h00C3);
      repeat (6) @(negedge clk);
      chk("R4 no start while disabled", 32'(spi_cs_n), 32'h1);
      chk("R4 word waits in buffer", 32'(tx_empty), 32'h0);
      bus_write(2'd0, 16'h0002);
      @(negedge clk);
      chk("R3 soft reset keeps tx word", 32'(tx_empty), 32'h0);
      bus_write(2'd0, 16'h0001);
      wait_rx();
      bus_read(2'd3, r);
      chk("R4 sent after enable rx", 32'(r), 32'h0081);
      chk("R4 sent after enable tx", 32'(cap_words[0]), 32'h00C3);
    end

    chk("R8 sclk period two cycles", 32'(bad_period), 32'h0);
    report();
  end
endmodule